// File: doc/BRIEF.md
# USB Low-Speed Line-State Driver

This block sits on the transmit side of a low-speed USB link, between the logic that decides which bus symbol goes out in each bit period and the two data pads. Each request names one symbol: J (differential 1), K (differential 0), single-ended zero, or release. The block turns that symbol into pad levels for the positive and negative data lines and a shared output enable. All three outputs come from one registered word, so the two lines always move on the same clock edge. The bus therefore never shows a stray equal-level pair while it passes from J to K or back.

The bit period is set by a one-cycle clock-enable tick. Requests are taken only in a cycle where the tick is high, and the outputs hold between ticks. The block also has an end-of-packet sequencer. One request starts it, and it then owns the lines. It drives single-ended zero for a set number of bit times and then one bit time of J. On the next tick it lets go of the output enable. While it runs, all other requests are ignored.

Top module: `ls_line_driver`

## Requirements
- R1: After reset, line_oe is 0, line_dp is 1, line_dm is 0 and eop_busy is 0.
- R2: On a tick with req_valid high and req_sym = 2'b01 (J), the outputs after that edge are line_dp = 1, line_dm = 0, line_oe = 1.
- R3: On a tick with req_valid high and req_sym = 2'b10 (K), the outputs after that edge are line_dp = 0, line_dm = 1, line_oe = 1.
- R4: On a tick with req_valid high and req_sym = 2'b11 (SE0), the outputs after that edge are line_dp = 0, line_dm = 0, line_oe = 1.
- R5: On a tick with req_valid high and req_sym = 2'b00 (release), line_oe becomes 0 and the lines rest at the J levels (line_dp = 1, line_dm = 0).
- R6: In a cycle where bit_tick is low, req_valid, req_sym and eop_req are ignored, and every output keeps its value across that edge.
- R7: line_dp and line_dm are never both 1. Whenever line_oe is 1 and the lines are not both 0, they are complementary, including on every J to K and K to J change.
- R8: On a tick with eop_req high while eop_busy is 0, the lines go to SE0 with line_oe = 1. They stay at SE0 for EOP_SE0_BITS ticks in total, show J for the next tick, and drop line_oe on the tick after that. When leaving SE0 only line_dp rises. eop_busy is high from the first SE0 edge up to the edge that drops line_oe.
- R9: While eop_busy is 1, req_valid, req_sym and eop_req have no effect on the outputs. In particular, K never appears on the lines.
- R10: When eop_req and req_valid are both high on a tick with eop_busy at 0, the end-of-packet sequence starts and the symbol request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle clock enable marking a bit boundary |
| req_valid | input | 1 | A symbol request is present this cycle |
| req_sym | input | 2 | Requested symbol: 00 release, 01 J, 10 K, 11 SE0 |
| eop_req | input | 1 | Start the end-of-packet sequence |
| line_dp | output | 1 | Positive data line level |
| line_dm | output | 1 | Negative data line level |
| line_oe | output | 1 | Output enable shared by both pads |
| eop_busy | output | 1 | End-of-packet sequence owns the lines |

## Verification
The bench builds the block with EOP_SE0_BITS left at its default of 2. With that value, one end-of-packet sequence completes in four ticks, so a random run with frequent tick gaps covers many complete sequences. It also covers many requests that arrive in each phase of a sequence: the first SE0, the second SE0, the closing J, and the release edge. Directed cases add a priority collision and back-to-back sequences, and the bench checks on every step that the two lines stay complementary and are never both high.

// File: rtl/ls_line_pkg.sv
package ls_line_pkg;

    typedef enum logic [1:0] {
        SYM_RELEASE = 2'b00,
        SYM_J       = 2'b01,
        SYM_K       = 2'b10,
        SYM_SE0     = 2'b11
    } ls_sym_e;

    typedef struct packed {
        logic dp;
        logic dm;
        logic oe;
    } ls_line_t;

    typedef enum logic [1:0] {
        EOP_IDLE = 2'b00,
        EOP_SE0  = 2'b01,
        EOP_JEND = 2'b10
    } eop_state_e;

    localparam ls_line_t LINE_RESET = '{dp: 1'b1, dm: 1'b0, oe: 1'b0};

    function automatic ls_line_t sym_to_line(ls_sym_e s);
        ls_line_t l;
        unique case (s)
            SYM_J:   l = '{dp: 1'b1, dm: 1'b0, oe: 1'b1};
            SYM_K:   l = '{dp: 1'b0, dm: 1'b1, oe: 1'b1};
            SYM_SE0: l = '{dp: 1'b0, dm: 1'b0, oe: 1'b1};
            default: l = LINE_RESET;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ls_eop_seq.sv
module ls_eop_seq
    import ls_line_pkg::*;
#(
    parameter int SE0_BITS = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    start,
    output logic    drive_valid,
    output ls_sym_e drive_sym,
    output logic    busy
);

    localparam int CNT_W = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SE0_BITS - 1);

    typedef struct packed {
        eop_state_e       state;
        logic [CNT_W-1:0] left;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        drive_valid = 1'b0;
        drive_sym   = SYM_RELEASE;
        if (tick) begin
            unique case (seq_q.state)
                EOP_IDLE: begin
                    if (start) begin
                        drive_valid = 1'b1;
                        drive_sym   = SYM_SE0;
                        seq_d.state = (SE0_BITS > 1) ? EOP_SE0 : EOP_JEND;
                        seq_d.left  = CNT_LOAD;
                    end
                end
                EOP_SE0: begin
                    drive_valid = 1'b1;
                    if (seq_q.left > CNT_W'(1)) begin
                        drive_sym  = SYM_SE0;
                        seq_d.left = seq_q.left - CNT_W'(1);
                    end else begin
                        drive_sym   = SYM_SE0;
                        seq_d.left  = '0;
                        seq_d.state = EOP_JEND;
                    end
                end
                EOP_JEND: begin
                    drive_valid = 1'b1;
                    if (seq_q.left == '0) begin
                        drive_sym  = SYM_J;
                        seq_d.left = CNT_W'(1);
                    end else begin
                        drive_sym   = SYM_RELEASE;
                        seq_d.state = EOP_IDLE;
                        seq_d.left  = '0;
                    end
                end
                default: seq_d.state = EOP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: EOP_IDLE, left: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.state != EOP_IDLE);

    AST_SEQ_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seq_q)) else $error("sequencer moved without tick"); // R6

    AST_SEQ_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.state != 2'b11) else $error("sequencer in unused state"); // R8

    AST_SEQ_NEVER_K: assert property (@(posedge clk) disable iff (!rst_n)
        drive_valid |-> drive_sym != SYM_K) else $error("sequencer drove K"); // R9

endmodule

// File: rtl/ls_line_reg.sv
module ls_line_reg
    import ls_line_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     upd_valid,
    input  ls_sym_e  upd_sym,
    output ls_line_t line
);

    ls_line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (tick && upd_valid) begin
            line_d = sym_to_line(upd_sym);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= LINE_RESET;
        end else begin
            line_q <= line_d;
        end
    end

    assign line = line_q;

    AST_NEVER_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_q.dp && line_q.dm)) else $error("both lines high"); // R7

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_q)) else $error("lines moved without tick"); // R6

    AST_RELEASE_AT_J: assert property (@(posedge clk) disable iff (!rst_n)
        !line_q.oe |-> (line_q.dp && !line_q.dm)) else $error("released lines not at J"); // R5

endmodule

// File: rtl/ls_line_driver.sv
module ls_line_driver
    import ls_line_pkg::*;
#(
    parameter int EOP_SE0_BITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       req_valid,
    input  logic [1:0] req_sym,
    input  logic       eop_req,
    output logic       line_dp,
    output logic       line_dm,
    output logic       line_oe,
    output logic       eop_busy
);

    logic     seq_valid;
    ls_sym_e  seq_sym;
    logic     seq_busy;
    logic     upd_valid;
    ls_sym_e  upd_sym;
    ls_line_t line_w;

    ls_eop_seq #(.SE0_BITS(EOP_SE0_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (bit_tick),
        .start       (eop_req),
        .drive_valid (seq_valid),
        .drive_sym   (seq_sym),
        .busy        (seq_busy)
    );

    always_comb begin
        if (seq_valid) begin
            upd_valid = 1'b1;
            upd_sym   = seq_sym;
        end else if (!seq_busy && !eop_req) begin
            upd_valid = req_valid;
            upd_sym   = ls_sym_e'(req_sym);
        end else begin
            upd_valid = 1'b0;
            upd_sym   = SYM_RELEASE;
        end
    end

    ls_line_reg u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .upd_valid (upd_valid),
        .upd_sym   (upd_sym),
        .line      (line_w)
    );

    assign line_dp  = line_w.dp;
    assign line_dm  = line_w.dm;
    assign line_oe  = line_w.oe;
    assign eop_busy = seq_busy;

    AST_EOP_STARTS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && eop_req && !eop_busy) |=> (line_oe && !line_dp && !line_dm && eop_busy))
        else $error("end of packet did not start with SE0"); // R8

    AST_EOP_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eop_busy) |-> !line_oe) else $error("enable kept after sequence"); // R8

    AST_BUSY_NO_K: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_busy && bit_tick) |=> !(line_oe && !line_dp && line_dm))
        else $error("K seen during end of packet"); // R9

    AST_EOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !eop_busy && eop_req && req_valid) |=> (!line_dp && !line_dm))
        else $error("symbol request beat end of packet"); // R10

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && (line_dp || line_dm)) |-> (line_dp != line_dm))
        else $error("equal lines outside SE0"); // R7

endmodule

// File: tb/sim_ls_line_driver.sv
module sim_ls_line_driver;

    localparam int CLK_P    = 10;
    localparam int SE0_BITS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_sym = 2'b00;
    logic       eop_req = 1'b0;
    logic       line_dp, line_dm, line_oe, eop_busy;

    int n_run  = 0;
    int n_fail = 0;

    logic exp_dp = 1'b1, exp_dm = 1'b0, exp_oe = 1'b0;
    int   m_state = 0;
    int   m_left  = 0;

    always #(CLK_P/2) clk = ~clk;

    ls_line_driver #(.EOP_SE0_BITS(SE0_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .req_valid(req_valid),
        .req_sym(req_sym), .eop_req(eop_req), .line_dp(line_dp), .line_dm(line_dm),
        .line_oe(line_oe), .eop_busy(eop_busy)
    );

    task automatic set_sym(logic [1:0] s);
        case (s)
            2'b01: begin exp_dp = 1; exp_dm = 0; exp_oe = 1; end
            2'b10: begin exp_dp = 0; exp_dm = 1; exp_oe = 1; end
            2'b11: begin exp_dp = 0; exp_dm = 0; exp_oe = 1; end
            default: begin exp_dp = 1; exp_dm = 0; exp_oe = 0; end
        endcase
    endtask

    // Expected outputs derived from R2..R10
    task automatic model(bit t, bit v, logic [1:0] s, bit e);
        if (!t) return;
        if (m_state == 1) begin
            set_sym(2'b11);
            m_left--;
            if (m_left == 0) m_state = 2;
        end else if (m_state == 2) begin
            set_sym(2'b01);
            m_state = 3;
        end else if (m_state == 3) begin
            set_sym(2'b00);
            m_state = 0;
        end else if (e) begin
            set_sym(2'b11);
            m_left = SE0_BITS - 1;
            m_state = (m_left == 0) ? 2 : 1;
        end else if (v) begin
            set_sym(s);
        end
    endtask

    task automatic check(string tag);
        logic exp_busy;
        exp_busy = (m_state != 0);
        n_run++;
        if ({line_dp, line_dm, line_oe, eop_busy} !== {exp_dp, exp_dm, exp_oe, exp_busy}) begin
            n_fail++;
            $display("FAIL %s: dp/dm/oe/busy got %b%b%b%b expected %b%b%b%b", tag,
                     line_dp, line_dm, line_oe, eop_busy, exp_dp, exp_dm, exp_oe, exp_busy);
        end
        n_run++;
        if ((line_dp && line_dm) || (line_oe && (line_dp || line_dm) && line_dp == line_dm)) begin
            n_fail++;
            $display("FAIL R7: illegal pair dp=%b dm=%b oe=%b expected complementary or SE0",
                     line_dp, line_dm, line_oe);
        end
    endtask

    task automatic step(bit t, bit v, logic [1:0] s, bit e, string tag);
        @(negedge clk);
        bit_tick = t; req_valid = v; req_sym = s; eop_req = e;
        @(posedge clk);
        model(t, v, s, e);
        #(CLK_P/4);
        check(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 1, 2'b01, 0, "R2");
        step(1, 1, 2'b10, 0, "R3");
        step(1, 1, 2'b01, 0, "R7");
        step(0, 1, 2'b11, 0, "R6");
        step(0, 0, 2'b00, 1, "R6");
        step(1, 1, 2'b11, 0, "R4");
        step(1, 1, 2'b01, 0, "R4");
        step(1, 1, 2'b00, 0, "R5");
        step(0, 1, 2'b10, 0, "R6");

        // full end of packet with gaps and blocked requests
        step(1, 1, 2'b10, 0, "R3");
        step(1, 0, 2'b00, 1, "R8");
        step(0, 1, 2'b10, 0, "R6");
        step(1, 1, 2'b10, 1, "R9");
        step(1, 1, 2'b10, 0, "R8");
        step(1, 0, 2'b00, 1, "R9");
        step(1, 1, 2'b10, 0, "R8");

        // priority collision and back-to-back sequences
        step(1, 1, 2'b10, 1, "R10");
        step(1, 0, 2'b00, 0, "R8");
        step(1, 0, 2'b00, 0, "R8");
        step(1, 0, 2'b00, 1, "R8");
        step(1, 0, 2'b00, 1, "R8");

        for (int i = 0; i < 600; i++) begin
            bit t, v, e;
            logic [1:0] s;
            t = ($urandom % 10) < 7;
            v = ($urandom % 10) < 6;
            e = ($urandom % 10) < 1;
            s = 2'($urandom);
            step(t, v, s, e, (m_state != 0) ? "R9" : "R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule